// File: doc/BRIEF.md
# Configurable Logic Cell with Output Conditioning

This block is a single programmable logic cell. Three raw inputs enter it. Each one is routed according to its own source select. An input can be masked to zero, taken as a plain level, or treated as an event line. An event line is reduced to a one-clock pulse on its leading edge. The three routed values form a 3-bit index into an 8-bit truth table, and the table bit at that index is the raw cell result.

The raw result can be conditioned before it reaches the outputs. A two-flop synchroniser brings it into the cell clock domain. A glitch filter then passes a level only after several consecutive equal synchronised samples. An edge stage can turn the conditioned level into a one-clock pulse on either its rising or its falling edge. With all conditioning off, the table result reaches the output combinationally.

The cell output and the event output always carry the same value. Both are forced low while the cell is disabled. Software must keep the cell disabled while it changes the truth table or the input selects. Disabling the cell also clears all of its internal state.

Top module: `cfg_logic_cell`

## Requirements
- R1: With `sync_en`, `filt_en` and `edge_en` all 0 and the cell enabled, `cell_out` equals `truth[{v2,v1,v0}]` in the same cycle. Here `vi` is the routed value of input i, and a level-selected input (select code 2'b01) routes `raw_in[i]` directly.
- R2: An input whose 2-bit select `src_sel[2i+1:2i]` is 2'b00 or 2'b11 is masked. Its routed value is 0, and its raw pin has no effect on the output.
- R3: While `cell_en` is 0, and during reset, `cell_out` and `evt_out` are both 0.
- R4: `evt_out` equals `cell_out` in every cycle.
- R5: With only `sync_en` set, a change of the table result made between clock edges reaches `cell_out` after the second following rising edge, and not before.
- R6: With `filt_en` set, a settled change of the table result reaches `cell_out` after the fifth following rising edge, and not earlier.
- R7: With `filt_en` set, a table-result pulse that lasts one or two clock cycles never reaches `cell_out`. A pulse of three cycles does reach it.
- R8: With `edge_en` set and `edge_fall` 0, a rising edge of the conditioned result gives exactly one `cell_out` pulse of one clock period, after the next rising clock edge. A held high level gives no further pulse.
- R9: With `edge_en` and `edge_fall` set, a one-clock pulse follows each falling edge of the conditioned result, and a rising edge gives none.
- R10: An input with select code 2'b10 (event) routes a single one-clock pulse when its raw line rises, whatever the width of the event. This pulse appears after the first rising clock edge at which the line is seen high, and it happens even when `edge_en` is 0.
- R11: The event-input pulse is triggered only by the rising edge of the raw line, even when the truth table treats that input as active low. A falling raw line produces no change at the output.
- R12: Setting `filt_en` routes the result through the synchroniser even when `sync_en` is 0, so the filtered output never follows an input change combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_en | input | 1 | Cell enable; 0 forces outputs low and clears state |
| raw_in | input | N_IN | Raw input lines (pin, neighbour cell or event) |
| src_sel | input | 2*N_IN | Per-input source: 00/11 masked, 01 level, 10 event |
| truth | input | 2**N_IN | Truth table indexed by the routed inputs |
| sync_en | input | 1 | Enable the two-flop synchroniser |
| filt_en | input | 1 | Enable the glitch filter (implies synchroniser) |
| edge_en | input | 1 | Convert the conditioned result to edge pulses |
| edge_fall | input | 1 | Edge polarity: 0 rising, 1 falling |
| cell_out | output | 1 | Cell output |
| evt_out | output | 1 | Event output, same value as cell_out |

## Verification
Some properties are checked on every cycle. The outputs stay quiet while the cell is disabled, and the event output mirrors the cell output. An edge-mode pulse never lasts longer than one clock. A filtered output, once it rises, holds for at least one more cycle. A routed event value never stays high for two cycles in a row. The exact latencies, the masking and the table lookup can only be shown by the bench's scenarios. So can the removal of one- and two-cycle pulses, and the polarity independence of the event pulse, because these depend on the stimulus history and on the expected values.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

    localparam int LC_INPUTS      = 3;
    localparam int LC_SYNC_STAGES = 2;
    localparam int LC_FILT_LEN    = 3;

    typedef enum logic [1:0] {
        SRC_MASK  = 2'b00,
        SRC_LEVEL = 2'b01,
        SRC_EVENT = 2'b10,
        SRC_OFF   = 2'b11
    } src_e;

    typedef struct packed {
        logic sync_en;
        logic filt_en;
        logic edge_en;
        logic edge_fall;
    } cond_cfg_t;

    function automatic logic all_equal(input logic [7:0] win, input int len);
        logic ones;
        logic zeros;
        ones  = 1'b1;
        zeros = 1'b1;
        for (int k = 0; k < 8; k++) begin
            if (k < len) begin
                ones  = ones & win[k];
                zeros = zeros & ~win[k];
            end
        end
        return ones | zeros;
    endfunction

endpackage

// File: rtl/lc_input_sel.sv
module lc_input_sel
    import lcell_pkg::*;
#(
    parameter int N_IN = LC_INPUTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [N_IN-1:0]   raw,
    input  logic [2*N_IN-1:0] sel,
    output logic [N_IN-1:0]   val
);

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
        logic seen_q;
        logic prev_q;
        src_e mode;

        assign mode = src_e'(sel[2*gi+1 -: 2]);

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                seen_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                seen_q <= raw[gi];
                prev_q <= seen_q;
            end
        end

        always_comb begin
            unique case (mode)
                SRC_LEVEL: val[gi] = raw[gi];
                SRC_EVENT: val[gi] = seen_q & ~prev_q;
                default:   val[gi] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/lc_sync.sv
module lc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                chain_q[k] <= chain_q[k-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/lc_filter.sv
module lc_filter
    import lcell_pkg::*;
#(
    parameter int LEN = LC_FILT_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic d,
    output logic q
);

    localparam int HIST = LEN - 1;

    logic [HIST-1:0] hist_q;
    logic [7:0]      window;
    logic            q_r;

    always_comb begin
        window = '0;
        window[0] = d;
        for (int k = 0; k < HIST; k++) begin
            window[k+1] = hist_q[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hist_q <= '0;
            q_r    <= 1'b0;
        end else begin
            hist_q[0] <= d;
            for (int k = 1; k < HIST; k++) begin
                hist_q[k] <= hist_q[k-1];
            end
            if (all_equal(window, LEN)) begin
                q_r <= d;
            end
        end
    end

    assign q = q_r;

endmodule

// File: rtl/lc_edge.sv
module lc_edge (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic d,
    input  logic fall,
    output logic pulse
);

    logic prev_q;
    logic pulse_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            prev_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            prev_q  <= d;
            pulse_q <= fall ? (~d & prev_q) : (d & ~prev_q);
        end
    end

    assign pulse = pulse_q;

endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
    import lcell_pkg::*;
#(
    parameter  int N_IN        = LC_INPUTS,
    parameter  int SYNC_STAGES = LC_SYNC_STAGES,
    parameter  int FILT_LEN    = LC_FILT_LEN,
    localparam int TT_W        = 1 << N_IN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cell_en,
    input  logic [N_IN-1:0]   raw_in,
    input  logic [2*N_IN-1:0] src_sel,
    input  logic [TT_W-1:0]   truth,
    input  logic              sync_en,
    input  logic              filt_en,
    input  logic              edge_en,
    input  logic              edge_fall,
    output logic              cell_out,
    output logic              evt_out
);

    cond_cfg_t       cfg;
    logic            clr;
    logic [N_IN-1:0] in_val;
    logic            tt_res;
    logic            sync_q;
    logic            filt_q;
    logic            cond;
    logic            edge_q;

    assign cfg = '{sync_en: sync_en, filt_en: filt_en,
                   edge_en: edge_en, edge_fall: edge_fall};
    assign clr = ~cell_en;

    lc_input_sel #(.N_IN(N_IN)) u_in (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .raw (raw_in),
        .sel (src_sel),
        .val (in_val)
    );

    assign tt_res = truth[in_val];

    lc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .d   (tt_res),
        .q   (sync_q)
    );

    lc_filter #(.LEN(FILT_LEN)) u_filt (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .d   (sync_q),
        .q   (filt_q)
    );

    always_comb begin
        if (cfg.filt_en)      cond = filt_q;
        else if (cfg.sync_en) cond = sync_q;
        else                  cond = tt_res;
    end

    lc_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .d     (cond),
        .fall  (cfg.edge_fall),
        .pulse (edge_q)
    );

    assign cell_out = cell_en & ~rst & (cfg.edge_en ? edge_q : cond);
    assign evt_out  = cell_out;

endmodule

// File: rtl/cfg_logic_cell_chk.sv
module cfg_logic_cell_chk #(
    parameter int N_IN = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cell_en,
    input logic [2*N_IN-1:0] src_sel,
    input logic [N_IN-1:0]   in_val,
    input logic              filt_en,
    input logic              edge_en,
    input logic              edge_fall,
    input logic              cell_out,
    input logic              evt_out
);

    AST_DIS_QUIET: assert property (@(posedge clk)
        !cell_en |-> (!cell_out && !evt_out)); // R3

    AST_EVT_MIRROR: assert property (@(posedge clk) disable iff (rst)
        evt_out == cell_out); // R4

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (cell_en && edge_en && cell_out) |=>
        (!cell_out || !edge_en || !cell_en || edge_fall != $past(edge_fall))); // R8

    AST_FILT_NO_RUNT: assert property (@(posedge clk) disable iff (rst)
        (cell_en && $past(cell_en) && filt_en && $past(filt_en) &&
         !edge_en && !$past(edge_en) && $rose(cell_out)) |=>
        (cell_out || !cell_en || !filt_en || edge_en)); // R7

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_evchk
        AST_EVPULSE_ONE: assert property (@(posedge clk) disable iff (rst)
            (in_val[gi] && src_sel[2*gi+1 -: 2] == 2'b10) |=>
            (!in_val[gi] || src_sel[2*gi+1 -: 2] != 2'b10)); // R10
    end

endmodule

bind cfg_logic_cell cfg_logic_cell_chk #(.N_IN(N_IN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cell_en   (cell_en),
    .src_sel   (src_sel),
    .in_val    (in_val),
    .filt_en   (filt_en),
    .edge_en   (edge_en),
    .edge_fall (edge_fall),
    .cell_out  (cell_out),
    .evt_out   (evt_out)
);

// File: tb/cfg_logic_cell_bench.sv
module cfg_logic_cell_bench;

    localparam int CLK_P = 10;
    localparam int NV    = 10;
    // {src_sel[5:0], truth[7:0], raw[2:0], expected}
    localparam logic [17:0] VEC [NV] = '{
        {6'b010101, 8'h80, 3'b111, 1'b1},
        {6'b010101, 8'h80, 3'b110, 1'b0},
        {6'b010101, 8'hFE, 3'b000, 1'b0},
        {6'b010101, 8'hFE, 3'b100, 1'b1},
        {6'b010101, 8'h96, 3'b011, 1'b0},
        {6'b010101, 8'h96, 3'b111, 1'b1},
        {6'b010101, 8'hA5, 3'b101, 1'b1},
        {6'b000101, 8'h08, 3'b111, 1'b1},
        {6'b110101, 8'h08, 3'b111, 1'b1},
        {6'b010100, 8'h40, 3'b111, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       cell_en;
    logic [2:0] raw_in;
    logic [5:0] src_sel;
    logic [7:0] truth;
    logic       sync_en, filt_en, edge_en, edge_fall;
    logic       cell_out, evt_out;
    int         n_run  = 0;
    int         n_fail = 0;
    logic       seen;

    always #(CLK_P/2) clk = ~clk;

    cfg_logic_cell u_cfg_logic_cell (
        .clk(clk), .rst(rst), .cell_en(cell_en), .raw_in(raw_in),
        .src_sel(src_sel), .truth(truth), .sync_en(sync_en),
        .filt_en(filt_en), .edge_en(edge_en), .edge_fall(edge_fall),
        .cell_out(cell_out), .evt_out(evt_out)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic exp);
        n_run++;
        if (cell_out !== exp) begin
            n_fail++;
            $display("FAIL %s: cell_out=%b expected=%b", tag, cell_out, exp);
        end
        n_run++;
        if (evt_out !== cell_out) begin
            n_fail++;
            $display("FAIL R4: evt_out=%b expected=%b", evt_out, cell_out);
        end
    endtask

    task automatic setup(input logic [5:0] s, input logic [7:0] t,
                         input logic sy, input logic fi, input logic ed,
                         input logic fa, input logic [2:0] r);
        cell_en = 1'b0;
        src_sel = s; truth = t;
        sync_en = sy; filt_en = fi; edge_en = ed; edge_fall = fa;
        raw_in = r;
        step();
        cell_en = 1'b1;
        repeat (8) step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cell_en = 1'b0; raw_in = 3'b111; src_sel = 6'b010101;
        truth = 8'hFF; sync_en = 0; filt_en = 0; edge_en = 0; edge_fall = 0;
        repeat (3) step();
        check("R3 reset", 1'b0);
        rst = 1'b0;
        step();
        check("R3 disabled", 1'b0);

        // R1 and R2: table walk, all conditioning off
        cell_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            src_sel = VEC[i][17:12];
            truth   = VEC[i][11:4];
            raw_in  = VEC[i][3:1];
            #1;
            check(i < 7 ? "R1 table" : "R2 mask", VEC[i][0]);
            step();
        end
        // R2: masked pin toggles, output stays
        src_sel = 6'b000001; truth = 8'hF0; raw_in = 3'b100;
        #1; check("R2 masked pin", 1'b0);

        // R5 synchroniser delay
        setup(6'b000001, 8'hAA, 1, 0, 0, 0, 3'b000);
        raw_in = 3'b001;
        #1; check("R5 no comb", 1'b0);
        step(); check("R5 edge1", 1'b0);
        step(); check("R5 edge2", 1'b1);

        // R6 / R12 filter delay, sync_en off
        setup(6'b000001, 8'hAA, 0, 1, 0, 0, 3'b000);
        raw_in = 3'b001;
        #1; check("R12 no comb", 1'b0);
        repeat (4) step();
        check("R6 edge4", 1'b0);
        step(); check("R6 edge5", 1'b1);

        // R7 runt removal
        setup(6'b000001, 8'hAA, 0, 1, 0, 0, 3'b000);
        raw_in = 3'b001; step(); raw_in = 3'b000;
        seen = 1'b0;
        repeat (10) begin step(); seen |= cell_out; end
        n_run++;
        if (seen !== 1'b0) begin n_fail++; $display("FAIL R7 1-cycle: seen=%b expected=0", seen); end
        raw_in = 3'b001; step(); step(); raw_in = 3'b000;
        seen = 1'b0;
        repeat (10) begin step(); seen |= cell_out; end
        n_run++;
        if (seen !== 1'b0) begin n_fail++; $display("FAIL R7 2-cycle: seen=%b expected=0", seen); end
        raw_in = 3'b001; repeat (3) step(); raw_in = 3'b000;
        seen = 1'b0;
        repeat (10) begin step(); seen |= cell_out; end
        n_run++;
        if (seen !== 1'b1) begin n_fail++; $display("FAIL R7 3-cycle: seen=%b expected=1", seen); end

        // R8 rising edge pulse
        setup(6'b000001, 8'hAA, 0, 0, 1, 0, 3'b000);
        raw_in = 3'b001;
        #1; check("R8 before edge", 1'b0);
        step(); check("R8 pulse", 1'b1);
        step(); check("R8 pulse end", 1'b0);
        repeat (3) step();
        check("R8 held", 1'b0);

        // R9 falling edge pulse
        setup(6'b000001, 8'hAA, 0, 0, 1, 1, 3'b001);
        raw_in = 3'b000;
        step(); check("R9 fall pulse", 1'b1);
        step(); check("R9 pulse end", 1'b0);
        raw_in = 3'b001;
        step(); check("R9 rise ignored", 1'b0);

        // R10 event input, long event
        setup(6'b000010, 8'hAA, 0, 0, 0, 0, 3'b000);
        raw_in = 3'b001;
        step(); check("R10 pulse", 1'b1);
        step(); check("R10 one clock", 1'b0);
        repeat (5) step();
        check("R10 held event", 1'b0);
        raw_in = 3'b000;
        step(); step(); check("R10 trailing", 1'b0);

        // R11 active-low table use of event
        setup(6'b000010, 8'h55, 0, 0, 0, 0, 3'b000);
        check("R11 idle", 1'b1);
        raw_in = 3'b001;
        step(); check("R11 leading dip", 1'b0);
        step(); check("R11 restore", 1'b1);
        repeat (3) step();
        raw_in = 3'b000;
        step(); check("R11 trailing none", 1'b1);
        step(); check("R11 trailing none2", 1'b1);

        // R3 disable forces outputs low
        setup(6'b000001, 8'hAA, 0, 0, 0, 0, 3'b001);
        check("R3 enabled high", 1'b1);
        cell_en = 1'b0;
        #1; check("R3 disable", 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule